// File: doc/BRIEF.md
# Counter Configuration Register Bank

This block is the host-facing register file of an up/down pulse counter. A host reaches it through a synchronous single-cycle write strobe with a 5-bit word address and 16-bit data. Reads are combinational from the address. The bank holds the counter's settings: operating mode, software count direction, ring length, command word, preset value and two compare values. Each 32-bit setting is split over a low and a high word. The settings are driven to the counter core as plain outputs.

The counter's live present, maximum and minimum values are read straight from the core. A host write to one of them reaches the core as a one-cycle load strobe that carries the new 32-bit value. The compare results, terminal status and error flags supplied by the core are read-only. One word always returns a fixed identification code.

A legal mode write puts every other setting back to its default. It also clears every half-written 32-bit pair and loads zero into the three live values. An illegal mode code is refused and leaves a flag in the error word.

Top module: `ctr_cfg_bank`

## Requirements
- R1: After reset, the settings are: mode 0, direction 0, command 0, preset 0, ring length 65536 (word 3 reads 1, word 2 reads 0) and both compare values 32767. No load strobe is active.
- R2: A write of a value from 0 to 11 to word 0 stores it as the mode, which word 0 then reads back in its low 4 bits.
- R3: A write of a value above 11 to word 0 leaves the mode and all other settings unchanged and sets bit 15 of word 29. A later legal mode write clears that bit.
- R4: A legal mode write restores direction, command, ring length, preset and both compare values to their R1 defaults and discards any staged low word. A following high-word write then commits a zero low half.
- R5: In the cycle after a legal mode write, all three load strobes are high together and the load value is 0.
- R6: A write to the low word of a 32-bit pair (ring 2/3, preset 10/11, compare A 12/13, compare B 14/15) changes no output. A write to the high word commits {high, staged low} from the next cycle. The low address of a setting pair reads back the committed low half.
- R7: Words 20/21, 22/23 and 24/25 read the low and high halves of the live present, maximum and minimum inputs. A high-word write to one of them raises only that pair's load strobe for exactly one cycle, with load value {high, staged low}.
- R8: Word 26 reads the compare flags, word 27 the terminal flags, word 29 {error bit, 15 error flags}, and word 30 the constant 4010. Writes to these words have no effect.
- R9: Words 5 to 9, 16 to 19, 28 and 31 read 0. Writes to them change no setting and raise no load strobe.
- R10: Word 1 keeps only bit 0 of a write as the direction and reads it back in bit 0. Word 4 keeps all 16 bits as the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe, one cycle per word |
| host_addr | input | 5 | Word address for read and write |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr |
| cfg_mode | output | 4 | Operating mode code |
| cfg_dir | output | 1 | Software count direction |
| cfg_ring | output | 32 | Ring length |
| cfg_cmd | output | 16 | Command word |
| cfg_preset | output | 32 | Preset value |
| cfg_cmp_a | output | 32 | First compare value |
| cfg_cmp_b | output | 32 | Second compare value |
| live_pv | input | 32 | Present value from the counter core |
| live_max | input | 32 | Maximum value from the counter core |
| live_min | input | 32 | Minimum value from the counter core |
| cmp_flags | input | 16 | Compare result word |
| term_flags | input | 16 | Terminal status word |
| err_flags | input | 15 | Error flags from the core |
| ld_pv | output | 1 | Load strobe for the present value |
| ld_max | output | 1 | Load strobe for the maximum |
| ld_min | output | 1 | Load strobe for the minimum |
| ld_value | output | 32 | Value carried by the load strobes |

## Verification
The stimulus writes low words alone, then full low/high pairs. This separates staging from commit. Writing a low word and then a legal mode before the high word shows whether the mode write really discards the staging. Legal mode codes, the edge code 11 and codes 12 and 15 tell storing apart from refusing. Writes to reserved, read-only and live addresses, interleaved with setting writes, expose any decode overlap, because a behavioural model follows every output and the read data each cycle.

// File: rtl/ctr_cfg_pkg.sv
package ctr_cfg_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int DUAL_W   = 2 * WORD_W;
  localparam int NPAIR    = 7;   // 0..3 settings, 4..6 live values
  localparam int NLIVE    = 3;
  localparam int FIRST_LIVE = NPAIR - NLIVE;
  localparam int MODE_W   = 4;
  localparam int MODE_MAX = 11;

  localparam logic [ADDR_W-1:0] A_MODE = 5'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 5'd1;
  localparam logic [ADDR_W-1:0] A_CMD  = 5'd4;
  localparam logic [ADDR_W-1:0] A_CMPF = 5'd26;
  localparam logic [ADDR_W-1:0] A_TERM = 5'd27;
  localparam logic [ADDR_W-1:0] A_ERR  = 5'd29;
  localparam logic [ADDR_W-1:0] A_ID   = 5'd30;
  localparam logic [WORD_W-1:0] ID_CODE = 16'd4010;

  // Low-word address of each 32-bit pair; the high word sits one above.
  function automatic logic [ADDR_W-1:0] pair_lo(input int idx);
    case (idx)
      0: pair_lo = 5'd2;
      1: pair_lo = 5'd10;
      2: pair_lo = 5'd12;
      3: pair_lo = 5'd14;
      4: pair_lo = 5'd20;
      5: pair_lo = 5'd22;
      default: pair_lo = 5'd24;
    endcase
  endfunction

  function automatic logic [DUAL_W-1:0] pair_default(input int idx);
    case (idx)
      0: pair_default = 32'd65536;
      2, 3: pair_default = 32'd32767;
      default: pair_default = '0;
    endcase
  endfunction

  function automatic logic mode_ok(input logic [WORD_W-1:0] w);
    mode_ok = (w <= WORD_W'(MODE_MAX));
  endfunction
endpackage

// File: rtl/ctr_cfg_pair.sv
module ctr_cfg_pair #(
  parameter int W = 16,
  parameter logic [2*W-1:0] INIT = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W-1:0]   wdata,
  output logic [2*W-1:0] value
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      stage_q <= '0;
      value   <= INIT;
    end else begin
      if (wr_lo) stage_q <= wdata;
      if (wr_hi) value   <= {wdata, stage_q};
    end
  end
endmodule

// File: rtl/ctr_cfg_rdmux.sv
module ctr_cfg_rdmux
  import ctr_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [MODE_W-1:0] mode,
  input  logic              dir,
  input  logic [WORD_W-1:0] cmd,
  input  logic [DUAL_W-1:0] view [NPAIR],
  input  logic [WORD_W-1:0] cmp_flags,
  input  logic [WORD_W-1:0] term_flags,
  input  logic [WORD_W-1:0] err_word,
  output logic [WORD_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE: rdata = {{(WORD_W-MODE_W){1'b0}}, mode};
      A_DIR:  rdata = {{(WORD_W-1){1'b0}}, dir};
      A_CMD:  rdata = cmd;
      A_CMPF: rdata = cmp_flags;
      A_TERM: rdata = term_flags;
      A_ERR:  rdata = err_word;
      A_ID:   rdata = ID_CODE;
      default: rdata = '0;
    endcase
    for (int i = 0; i < NPAIR; i++) begin
      if (addr == pair_lo(i))         rdata = view[i][WORD_W-1:0];
      if (addr == pair_lo(i) + 5'd1)  rdata = view[i][DUAL_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/ctr_cfg_bank.sv
module ctr_cfg_bank
  import ctr_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [4:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic [3:0]  cfg_mode,
  output logic        cfg_dir,
  output logic [31:0] cfg_ring,
  output logic [15:0] cfg_cmd,
  output logic [31:0] cfg_preset,
  output logic [31:0] cfg_cmp_a,
  output logic [31:0] cfg_cmp_b,
  input  logic [31:0] live_pv,
  input  logic [31:0] live_max,
  input  logic [31:0] live_min,
  input  logic [15:0] cmp_flags,
  input  logic [15:0] term_flags,
  input  logic [14:0] err_flags,
  output logic        ld_pv,
  output logic        ld_max,
  output logic        ld_min,
  output logic [31:0] ld_value
);
  // Named decode events, also watched by the checker.
  logic mode_wr, mode_good, mode_bad, dir_wr, cmd_wr;
  assign mode_wr   = host_wr && (host_addr == A_MODE);
  assign mode_good = mode_wr && mode_ok(host_wdata);
  assign mode_bad  = mode_wr && !mode_ok(host_wdata);
  assign dir_wr    = host_wr && (host_addr == A_DIR);
  assign cmd_wr    = host_wr && (host_addr == A_CMD);

  logic [NPAIR-1:0]  lo_hit, hi_hit;
  logic [DUAL_W-1:0] pair_val [NPAIR];
  logic [DUAL_W-1:0] view     [NPAIR];

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    assign lo_hit[g] = host_wr && (host_addr == pair_lo(g));
    assign hi_hit[g] = host_wr && (host_addr == pair_lo(g) + 5'd1);
    ctr_cfg_pair #(.W(WORD_W), .INIT(pair_default(g))) u_pair (
      .clk(clk), .rst_n(rst_n), .clear(mode_good),
      .wr_lo(lo_hit[g]), .wr_hi(hi_hit[g]),
      .wdata(host_wdata), .value(pair_val[g])
    );
    if (g < FIRST_LIVE) begin : g_set
      assign view[g] = pair_val[g];
    end else if (g == FIRST_LIVE) begin : g_pv
      assign view[g] = live_pv;
    end else if (g == FIRST_LIVE + 1) begin : g_max
      assign view[g] = live_max;
    end else begin : g_min
      assign view[g] = live_min;
    end
  end

  logic [MODE_W-1:0] mode_q;
  logic              dir_q, mode_err_q;
  logic [WORD_W-1:0] cmd_q;
  logic [NLIVE-1:0]  ld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      dir_q      <= 1'b0;
      cmd_q      <= '0;
      mode_err_q <= 1'b0;
      ld_q       <= '0;
    end else begin
      ld_q <= mode_good ? {NLIVE{1'b1}} : hi_hit[NPAIR-1:FIRST_LIVE];
      if (mode_good) begin
        mode_q     <= host_wdata[MODE_W-1:0];
        dir_q      <= 1'b0;
        cmd_q      <= '0;
        mode_err_q <= 1'b0;
      end else begin
        if (mode_bad) mode_err_q <= 1'b1;
        if (dir_wr)   dir_q      <= host_wdata[0];
        if (cmd_wr)   cmd_q      <= host_wdata;
      end
    end
  end

  always_comb begin
    ld_value = '0;
    for (int k = 0; k < NLIVE; k++)
      ld_value = ld_value | ({DUAL_W{ld_q[k]}} & pair_val[FIRST_LIVE + k]);
  end

  ctr_cfg_rdmux u_rd (
    .addr(host_addr), .mode(mode_q), .dir(dir_q), .cmd(cmd_q), .view(view),
    .cmp_flags(cmp_flags), .term_flags(term_flags),
    .err_word({mode_err_q, err_flags}), .rdata(host_rdata)
  );

  assign cfg_mode   = mode_q;
  assign cfg_dir    = dir_q;
  assign cfg_cmd    = cmd_q;
  assign cfg_ring   = pair_val[0];
  assign cfg_preset = pair_val[1];
  assign cfg_cmp_a  = pair_val[2];
  assign cfg_cmp_b  = pair_val[3];
  assign ld_pv      = ld_q[0];
  assign ld_max     = ld_q[1];
  assign ld_min     = ld_q[2];
endmodule

// File: rtl/ctr_cfg_bank_chk.sv
module ctr_cfg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [4:0]  host_addr,
  input logic [15:0] host_wdata,
  input logic [15:0] host_rdata,
  input logic [3:0]  cfg_mode,
  input logic        cfg_dir,
  input logic [31:0] cfg_ring,
  input logic [15:0] cfg_cmd,
  input logic [31:0] cfg_preset,
  input logic [31:0] cfg_cmp_a,
  input logic [31:0] cfg_cmp_b,
  input logic        ld_pv,
  input logic        ld_max,
  input logic        ld_min,
  input logic [31:0] ld_value
);
  logic good_w, bad_w, rsv_w;
  assign good_w = host_wr && host_addr == 5'd0 && host_wdata <= 16'd11;
  assign bad_w  = host_wr && host_addr == 5'd0 && host_wdata > 16'd11;
  assign rsv_w  = host_wr && ((host_addr >= 5'd5 && host_addr <= 5'd9) ||
                  (host_addr >= 5'd16 && host_addr <= 5'd19) ||
                  host_addr == 5'd28 || host_addr == 5'd31);

  AST_BAD_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_w |=> $stable(cfg_mode) && $stable(cfg_ring) && $stable(cfg_dir)); // R3
  AST_MODE_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    good_w |=> cfg_ring == 32'd65536 && cfg_cmp_a == 32'd32767 &&
               cfg_cmp_b == 32'd32767 && cfg_preset == 32'd0 && !cfg_dir && cfg_cmd == 16'd0); // R4
  AST_MODE_LOADS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    good_w |=> ld_pv && ld_max && ld_min && ld_value == 32'd0); // R5
  AST_LOW_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 5'd10) |=> $stable(cfg_preset)); // R6
  AST_LOAD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_pv, ld_max, ld_min}) || (ld_pv && ld_max && ld_min)); // R7
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 5'd30 |-> host_rdata == 16'd4010); // R8
  AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_w |=> $stable(cfg_mode) && $stable(cfg_ring) && $stable(cfg_preset) &&
              $stable(cfg_cmp_a) && $stable(cfg_cmp_b) && $stable(cfg_cmd) &&
              !ld_pv && !ld_max && !ld_min); // R9
endmodule

bind ctr_cfg_bank ctr_cfg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_mode(cfg_mode),
  .cfg_dir(cfg_dir), .cfg_ring(cfg_ring), .cfg_cmd(cfg_cmd),
  .cfg_preset(cfg_preset), .cfg_cmp_a(cfg_cmp_a), .cfg_cmp_b(cfg_cmp_b),
  .ld_pv(ld_pv), .ld_max(ld_max), .ld_min(ld_min), .ld_value(ld_value)
);

// File: tb/ctr_cfg_bank_test.sv
module ctr_cfg_bank_test;
  logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic [3:0]  cfg_mode;
  logic        cfg_dir, ld_pv, ld_max, ld_min;
  logic [31:0] cfg_ring, cfg_preset, cfg_cmp_a, cfg_cmp_b, ld_value;
  logic [15:0] cfg_cmd;
  logic [31:0] live_pv = 32'h1111_2222, live_max = 32'h3333_4444, live_min = 32'h5555_6666;
  logic [15:0] cmp_flags = 16'h00A5, term_flags = 16'h0C03;
  logic [14:0] err_flags = 15'h0123;

  always #10 clk = ~clk;  // 50 MHz

  ctr_cfg_bank uut (.*);

  int errs = 0, checks = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int lo_addr [7] = '{2, 10, 12, 14, 20, 22, 24};
  bit [31:0] m_val [7], m_stg [7];
  int m_mode, m_dir, m_cmd, m_err, m_ld, m_ldv;

  function automatic bit [31:0] dflt(int i);
    return (i == 0) ? 32'h0001_0000 : (i == 2 || i == 3) ? 32'd32767 : 32'd0;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 7; i++) begin m_val[i] = dflt(i); m_stg[i] = 0; end
    m_dir = 0; m_cmd = 0;
  endtask

  function automatic bit [15:0] exp_read(int a);
    bit [31:0] src;
    for (int i = 0; i < 7; i++) begin
      src = (i == 4) ? live_pv : (i == 5) ? live_max : (i == 6) ? live_min : m_val[i];
      if (a == lo_addr[i]) return src[15:0];
      if (a == lo_addr[i] + 1) return src[31:16];
    end
    case (a)
      0: return 16'(m_mode);
      1: return 16'(m_dir);
      4: return 16'(m_cmd);
      26: return cmp_flags;
      27: return term_flags;
      29: return {m_err[0], err_flags};
      30: return 16'd4010;
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    int nld;
    nld = 0; m_ldv = 0;
    if (!rst_n) begin
      m_clear(); m_mode = 0; m_err = 0;
    end else if (host_wr) begin
      if (host_addr == 0) begin
        if (host_wdata <= 11) begin
          m_clear(); m_mode = host_wdata; m_err = 0; nld = 7;
        end else m_err = 1;
      end else begin
        for (int i = 0; i < 7; i++) begin
          if (host_addr == lo_addr[i]) m_stg[i] = host_wdata;
          if (host_addr == lo_addr[i] + 1) begin
            m_val[i] = {host_wdata, m_stg[i][15:0]};
            if (i >= 4) begin nld = 1 << (i - 4); m_ldv = m_val[i]; end
          end
        end
        if (host_addr == 1) m_dir = host_wdata[0];
        if (host_addr == 4) m_cmd = host_wdata;
      end
    end
    m_ld = nld;
    #5;
    chk("model mode", cfg_mode, m_mode);
    chk("model dir", cfg_dir, m_dir);
    chk("model cmd", cfg_cmd, m_cmd);
    chk("model ring", cfg_ring, m_val[0]);
    chk("model preset", cfg_preset, m_val[1]);
    chk("model cmp_a", cfg_cmp_a, m_val[2]);
    chk("model cmp_b", cfg_cmp_b, m_val[3]);
    chk("model loads", {ld_min, ld_max, ld_pv}, m_ld);
    chk("model ld_value", ld_value, m_ldv);
    chk("model rdata", host_rdata, exp_read(host_addr));
  end

  task automatic wr(int a, int d);
    @(negedge clk); host_wr = 1; host_addr = 5'(a); host_wdata = 16'(d);
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(int a, output logic [15:0] v);
    @(negedge clk); host_wr = 0; host_addr = 5'(a);
    #1 v = host_rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1 mode", v, 0);
    rd(2, v); chk("R1 ring lo", v, 0);
    rd(3, v); chk("R1 ring hi", v, 1);
    rd(13, v); chk("R1 cmp_a hi", v, 0);
    rd(14, v); chk("R1 cmp_b lo", v, 32767);
    chk("R1 ring out", cfg_ring, 32'd65536);
    chk("R1 loads", {ld_min, ld_max, ld_pv}, 0);
    // R10 direction and command
    wr(1, 16'hFFFE); chk("R10 dir bit0 only", cfg_dir, 0);
    wr(1, 16'hFFFF); chk("R10 dir", cfg_dir, 1);
    rd(1, v); chk("R10 dir read", v, 1);
    wr(4, 16'hBEEF); chk("R10 cmd", cfg_cmd, 16'hBEEF);
    // R6 staging and commit
    wr(10, 16'h1234); chk("R6 low staged", cfg_preset, 0);
    wr(11, 16'hABCD); chk("R6 commit", cfg_preset, 32'hABCD_1234);
    rd(10, v); chk("R6 low read", v, 16'h1234);
    wr(14, 5); wr(15, 0); chk("R6 cmp_b", cfg_cmp_b, 5);
    wr(3, 16'h0002); chk("R6 hi with old stage", cfg_ring, 32'h0002_0000);
    // R7 live values
    rd(20, v); chk("R7 pv lo", v, 16'h2222);
    rd(25, v); chk("R7 min hi", v, 16'h5555);
    wr(22, 16'h0007);
    chk("R7 no load on low", {ld_min, ld_max, ld_pv}, 0);
    wr(23, 16'h8000);
    chk("R7 max strobe", {ld_min, ld_max, ld_pv}, 3'b010);
    chk("R7 load value", ld_value, 32'h8000_0007);
    @(negedge clk); chk("R7 one cycle", {ld_min, ld_max, ld_pv}, 0);
    // R8 read-only words
    rd(26, v); chk("R8 cmp flags", v, 16'h00A5);
    rd(27, v); chk("R8 term flags", v, 16'h0C03);
    rd(29, v); chk("R8 err word", v, 16'h0123);
    wr(30, 0); rd(30, v); chk("R8 id", v, 16'd4010);
    wr(26, 16'hFFFF); rd(26, v); chk("R8 ro write", v, 16'h00A5);
    // R9 reserved
    wr(7, 16'hFFFF); chk("R9 no load", {ld_min, ld_max, ld_pv}, 0);
    rd(7, v); chk("R9 read zero", v, 0);
    wr(31, 16'h1234); rd(31, v); chk("R9 read 31", v, 0);
    wr(18, 16'h0001); chk("R9 ring kept", cfg_ring, 32'h0002_0000);
    // R3 illegal mode
    wr(0, 12); chk("R3 mode kept", cfg_mode, 0);
    chk("R3 dir kept", cfg_dir, 1);
    rd(29, v); chk("R3 err bit", v, 16'h8123);
    // R4 / R5 legal mode
    wr(2, 16'h0055);
    wr(0, 5);
    chk("R5 loads", {ld_min, ld_max, ld_pv}, 3'b111);
    chk("R5 load zero", ld_value, 0);
    chk("R2 mode", cfg_mode, 5);
    chk("R4 dir", cfg_dir, 0);
    chk("R4 cmd", cfg_cmd, 0);
    chk("R4 preset", cfg_preset, 0);
    chk("R4 cmp_b", cfg_cmp_b, 32767);
    chk("R4 ring", cfg_ring, 32'd65536);
    rd(29, v); chk("R3 err cleared", v, 16'h0123);
    wr(3, 0); chk("R4 stage discarded", cfg_ring, 0);
    // R2 edge codes
    wr(0, 11); rd(0, v); chk("R2 mode 11", v, 11);
    wr(0, 15); rd(0, v); chk("R3 mode 15 refused", v, 11);
    wr(24, 16'h0009); wr(25, 16'h0001);
    chk("R7 min strobe", {ld_min, ld_max, ld_pv}, 3'b100);
    chk("R7 min value", ld_value, 32'h0001_0009);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule